// File: doc/BRIEF.md
# Exception Entry Sequencer

This block steers a processor core from the moment a fault or an interrupt is detected to the cycle in which the fetch of the handler's first instruction is issued. The core presents each request as a one-cycle pulse carrying an exception type and, for interrupts, a request level. The block latches the request as pending and raises `busy`. While it is idle, it takes the highest-priority pending request and snapshots the status register, the supervisor stack pointer, the faulting program counter and the vector base.

For a fault, the vector number is derived from the exception type. For an interrupt, the vector number is fetched with an interrupt-acknowledge read whose address carries the level being serviced. A failed acknowledge falls back to the spurious vector. The block then pushes a fixed two-word frame onto the supervisor stack and reads the handler address from the vector table. Finally it pulses `handlerGo` together with the handler address, the new status register and the new supervisor stack pointer. The core holds `srIn`, `sspIn`, `faultPc` and `vbrIn` valid while a request is pending.

The bus port is a simple request/response master. `busReq` stays high with a stable address until one cycle of `busAck` or `busErr` is returned.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `busy`, `busReq` and `handlerGo` are 0.
- R2: The status register given with `handlerGo` always has the supervisor bit (bit 13) set and the trace bit (bit 15) clear. For faults, every other bit equals the status register sampled at entry.
- R3: For an interrupt (type 7), the new status register also has bit 12 clear and bits 10:8 equal to the level being serviced. All remaining bits come from the sampled value.
- R4: A fault of type t (0 to 6) uses vector number t + 2 and performs no acknowledge cycle.
- R5: An interrupt performs exactly one acknowledge read at address 0xFFFFFF00 + level*4 and uses `busRdata[7:0]` of that read as its vector number.
- R6: When the acknowledge read ends with `busErr`, vector number 24 is used instead.
- R7: The frame is built with two writes, in this order. First the program counter is written to SSP-4. Then word {4'h4, 4'h0, vector[7:0], savedSR[15:0]} is written to SSP-8. `sspNew` equals SSP-8.
- R8: After the frame, the block reads the word at vbr + vector*4. It then gives a one-cycle `handlerGo` pulse with `handlerPc` equal to that read data.
- R9: `busy` rises in the cycle after an accepted request and stays high until the cycle after the last `handlerGo`. Requests that arrive while busy are kept and served later. The lowest pending type is served first, so interrupts are served last.
- R10: Interrupts that arrive while pending merge into one entry at the highest level seen. An interrupt request with level 0 is ignored.
- R11: `busReq` stays high with an unchanged address until `busAck` or `busErr` is seen, and each access completes exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | One-cycle exception request pulse |
| excType | input | 3 | Exception type, 7 = interrupt |
| excLevel | input | 3 | Interrupt request level |
| srIn | input | 16 | Current status register |
| sspIn | input | 32 | Current supervisor stack pointer |
| faultPc | input | 32 | Program counter to save in the frame |
| vbrIn | input | 32 | Vector base |
| busReq | output | 1 | Bus access request |
| busWrite | output | 1 | 1 = write, 0 = read |
| busAddr | output | 32 | Access address |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data |
| busAck | input | 1 | Access done |
| busErr | input | 1 | Access ended with error |
| busy | output | 1 | Request pending or in service |
| handlerGo | output | 1 | Handler fetch issued (pulse) |
| handlerPc | output | 32 | Handler start address |
| srNew | output | 16 | Status register for the handler |
| sspNew | output | 32 | Supervisor stack pointer after the frame |

## Verification
A table of single requests covers several cases:
- faults at the lowest, a middle and the highest type, which separates the type-to-vector offset from a fixed vector;
- status values with trace, master and a full mask set, which shows which bits are forced and which are copied;
- one clean interrupt and one interrupt whose acknowledge fails, which separates the acknowledged vector from the spurious one.

One table entry is replayed with a slow bus, which shows that addresses are held and each access is counted once. A burst of mixed requests during service checks that no request is lost, that priority order is kept and that interrupt levels merge. A level-0 interrupt is sent to confirm that nothing starts.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IACK,
    ST_PUSH_PC,
    ST_PUSH_SR,
    ST_VREAD,
    ST_GO
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;      // snapshot core state, start an entry
    logic isIrq;        // entry being captured is an interrupt
    logic ackVec;       // take vector from acknowledge read data
    logic spurious;     // acknowledge failed, take spurious vector
    logic takeHandler;  // latch vector table read data
    logic go;           // handler fetch issued this cycle
  } dpCtl_t;

  localparam int SR_T    = 15;
  localparam int SR_S    = 13;
  localparam int SR_M    = 12;
  localparam int SR_MLO  = 8;
  localparam int SR_W    = 16;
  localparam int WORD_W  = 32;
  localparam int LVL_W   = 3;
  localparam int VEC_W   = 8;

endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int NUM_TYPES = 8,
  localparam int TYPE_W = $clog2(NUM_TYPES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 excReq,
  input  logic [TYPE_W-1:0]    excType,
  input  logic [LVL_W-1:0]     excLevel,
  input  logic                 busAck,
  input  logic                 busErr,
  output seqState_t            state,
  output dpCtl_t               ctl,
  output logic [TYPE_W-1:0]    selType,
  output logic [LVL_W-1:0]     selLevel,
  output logic                 busy,
  output logic                 busReq,
  output logic                 busWrite,
  output logic                 handlerGo
);

  localparam logic [TYPE_W-1:0] INT_T = TYPE_W'(NUM_TYPES - 1);

  seqState_t              stateNext;
  logic [NUM_TYPES-1:0]   pendMask, pendNext;
  logic [LVL_W-1:0]       pendLvl, lvlNext;
  logic                   anyPend, selIsIrq, validReq, busDone;

  // priority pick: lowest pending type index wins
  always_comb begin
    logic found;
    found   = 1'b0;
    selType = '0;
    for (int i = 0; i < NUM_TYPES; i++) begin
      if (pendMask[i] && !found) begin
        selType = TYPE_W'(i);
        found   = 1'b1;
      end
    end
  end

  assign anyPend  = |pendMask;
  assign selIsIrq = (selType == INT_T);
  assign selLevel = pendLvl;
  assign validReq = excReq && !((excType == INT_T) && (excLevel == '0));
  assign busDone  = busAck || busErr;

  // next state and strobes
  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (anyPend) begin
          ctl.capture = 1'b1;
          ctl.isIrq   = selIsIrq;
          stateNext   = selIsIrq ? ST_IACK : ST_PUSH_PC;
        end
      end
      ST_IACK: begin
        if (busAck) begin
          ctl.ackVec = 1'b1;
          stateNext  = ST_PUSH_PC;
        end else if (busErr) begin
          ctl.spurious = 1'b1;
          stateNext    = ST_PUSH_PC;
        end
      end
      ST_PUSH_PC: if (busDone) stateNext = ST_PUSH_SR;
      ST_PUSH_SR: if (busDone) stateNext = ST_VREAD;
      ST_VREAD: begin
        if (busDone) begin
          ctl.takeHandler = 1'b1;
          stateNext       = ST_GO;
        end
      end
      ST_GO: begin
        ctl.go    = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // pending set and level merge
  always_comb begin
    pendNext = pendMask;
    lvlNext  = pendLvl;
    if (ctl.capture) begin
      pendNext[selType] = 1'b0;
      if (selIsIrq) lvlNext = '0;
    end
    if (validReq) begin
      pendNext[excType] = 1'b1;
      if ((excType == INT_T) && (excLevel > lvlNext)) lvlNext = excLevel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pendMask <= '0;
      pendLvl  <= '0;
    end else begin
      state    <= stateNext;
      pendMask <= pendNext;
      pendLvl  <= lvlNext;
    end
  end

  assign busy      = anyPend || (state != ST_IDLE);
  assign busReq    = (state == ST_IACK) || (state == ST_PUSH_PC) ||
                     (state == ST_PUSH_SR) || (state == ST_VREAD);
  assign busWrite  = (state == ST_PUSH_PC) || (state == ST_PUSH_SR);
  assign handlerGo = (state == ST_GO);

  AST_BUSY_IN_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> busy);  // R9

  AST_REQ_NOT_LOST: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && !((excType == INT_T) && (excLevel == '0))) |=> busy);  // R9

  AST_LVL0_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && (excType == INT_T) && (excLevel == '0) && !busy) |=> !busy);  // R10

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck && !busErr) |=> (busReq && $stable(state)));  // R11

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    handlerGo |=> !handlerGo);  // R8

endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int NUM_TYPES = 8,
  parameter int FAULT_VEC_OFS = 2,
  parameter int SPURIOUS_VEC = 24,
  parameter logic [3:0] FRAME_FMT = 4'h4,
  parameter logic [WORD_W-1:0] IACK_BASE = 32'hFFFF_FF00,
  localparam int TYPE_W = $clog2(NUM_TYPES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  seqState_t            state,
  input  logic [TYPE_W-1:0]    selType,
  input  logic [LVL_W-1:0]     selLevel,
  input  logic [SR_W-1:0]      srIn,
  input  logic [WORD_W-1:0]    sspIn,
  input  logic [WORD_W-1:0]    faultPc,
  input  logic [WORD_W-1:0]    vbrIn,
  input  logic [WORD_W-1:0]    busRdata,
  output logic [WORD_W-1:0]    busAddr,
  output logic [WORD_W-1:0]    busWdata,
  output logic [SR_W-1:0]      srNew,
  output logic [WORD_W-1:0]    sspNew,
  output logic [WORD_W-1:0]    handlerPc
);

  localparam logic [VEC_W-1:0] SPUR_V = VEC_W'(SPURIOUS_VEC);
  localparam logic [VEC_W-1:0] OFS_V  = VEC_W'(FAULT_VEC_OFS);

  logic [SR_W-1:0]   savedSr, entrySr;
  logic [WORD_W-1:0] frameSp, savedPc, vbrReg, frameWord0;
  logic [VEC_W-1:0]  vecNum, faultVec;
  logic [LVL_W-1:0]  lvl;

  assign faultVec = VEC_W'(selType) + OFS_V;

  // status register as seen by the handler
  always_comb begin
    entrySr        = srIn;
    entrySr[SR_S]  = 1'b1;
    entrySr[SR_T]  = 1'b0;
    if (ctl.isIrq) begin
      entrySr[SR_M]                  = 1'b0;
      entrySr[SR_MLO+LVL_W-1:SR_MLO] = selLevel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedSr   <= '0;
      srNew     <= '0;
      frameSp   <= '0;
      savedPc   <= '0;
      vbrReg    <= '0;
      vecNum    <= '0;
      lvl       <= '0;
      handlerPc <= '0;
    end else begin
      if (ctl.capture) begin
        savedSr <= srIn;
        srNew   <= entrySr;
        frameSp <= sspIn;
        savedPc <= faultPc;
        vbrReg  <= vbrIn;
        lvl     <= selLevel;
        vecNum  <= ctl.isIrq ? '0 : faultVec;
      end
      if (ctl.ackVec)      vecNum    <= busRdata[VEC_W-1:0];
      if (ctl.spurious)    vecNum    <= SPUR_V;
      if (ctl.takeHandler) handlerPc <= busRdata;
    end
  end

  assign frameWord0 = {FRAME_FMT, 4'h0, vecNum, savedSr};
  assign sspNew     = frameSp - WORD_W'(8);

  always_comb begin
    busAddr  = '0;
    busWdata = '0;
    unique case (state)
      ST_IACK:    busAddr = IACK_BASE + WORD_W'({lvl, 2'b00});
      ST_PUSH_PC: begin
        busAddr  = frameSp - WORD_W'(4);
        busWdata = savedPc;
      end
      ST_PUSH_SR: begin
        busAddr  = frameSp - WORD_W'(8);
        busWdata = frameWord0;
      end
      ST_VREAD:   busAddr = vbrReg + WORD_W'({vecNum, 2'b00});
      default: ;
    endcase
  end

  AST_SUPER_ON_GO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.go |-> (srNew[SR_S] && !srNew[SR_T]));  // R2

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int NUM_TYPES = 8,
  parameter int FAULT_VEC_OFS = 2,
  parameter int SPURIOUS_VEC = 24,
  parameter logic [3:0] FRAME_FMT = 4'h4,
  parameter logic [31:0] IACK_BASE = 32'hFFFF_FF00,
  localparam int TYPE_W = $clog2(NUM_TYPES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [TYPE_W-1:0] excType,
  input  logic [2:0]        excLevel,
  input  logic [15:0]       srIn,
  input  logic [31:0]       sspIn,
  input  logic [31:0]       faultPc,
  input  logic [31:0]       vbrIn,
  output logic              busReq,
  output logic              busWrite,
  output logic [31:0]       busAddr,
  output logic [31:0]       busWdata,
  input  logic [31:0]       busRdata,
  input  logic              busAck,
  input  logic              busErr,
  output logic              busy,
  output logic              handlerGo,
  output logic [31:0]       handlerPc,
  output logic [15:0]       srNew,
  output logic [31:0]       sspNew
);

  seqState_t         state;
  dpCtl_t            ctl;
  logic [TYPE_W-1:0] selType;
  logic [LVL_W-1:0]  selLevel;

  exc_entry_ctrl #(.NUM_TYPES(NUM_TYPES)) uCtrl (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excType(excType),
    .excLevel(excLevel), .busAck(busAck), .busErr(busErr),
    .state(state), .ctl(ctl), .selType(selType), .selLevel(selLevel),
    .busy(busy), .busReq(busReq), .busWrite(busWrite), .handlerGo(handlerGo)
  );

  exc_entry_dp #(
    .NUM_TYPES(NUM_TYPES), .FAULT_VEC_OFS(FAULT_VEC_OFS),
    .SPURIOUS_VEC(SPURIOUS_VEC), .FRAME_FMT(FRAME_FMT), .IACK_BASE(IACK_BASE)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .state(state), .selType(selType),
    .selLevel(selLevel), .srIn(srIn), .sspIn(sspIn), .faultPc(faultPc),
    .vbrIn(vbrIn), .busRdata(busRdata), .busAddr(busAddr),
    .busWdata(busWdata), .srNew(srNew), .sspNew(sspNew), .handlerPc(handlerPc)
  );

endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;

  localparam logic [31:0] IACK_BASE = 32'hFFFF_FF00;
  localparam logic [31:0] VBR       = 32'h0004_0000;
  localparam logic [31:0] TBL_XOR   = 32'h5A5A_0000;

  typedef struct packed {
    logic [2:0]  typ;
    logic [2:0]  lvl;
    logic [15:0] sr;
    logic [31:0] ssp;
    logic [31:0] pc;
    logic [7:0]  ackVec;
    logic        ackErr;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 16'h0000, 32'h0000_8000, 32'h1000_0100, 8'h00, 1'b0},
    '{3'd3, 3'd0, 16'hA715, 32'h0001_0000, 32'h1000_2004, 8'h00, 1'b0},
    '{3'd6, 3'd0, 16'h1300, 32'h0002_0010, 32'h2000_0000, 8'h00, 1'b0},
    '{3'd7, 3'd3, 16'h9700, 32'h0000_4000, 32'h3000_0040, 8'h40, 1'b0},
    '{3'd7, 3'd7, 16'h0000, 32'h0000_5000, 32'h3000_1000, 8'h55, 1'b1},
    '{3'd5, 3'd0, 16'h20FF, 32'h0000_6008, 32'h4000_000C, 8'h00, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic excReq = 1'b0;
  logic [2:0] excType = '0, excLevel = '0;
  logic [15:0] srIn = '0;
  logic [31:0] sspIn = '0, faultPc = '0, vbrIn = VBR;
  logic busReq, busWrite, busy, handlerGo;
  logic [31:0] busAddr, busWdata, handlerPc, sspNew;
  logic [15:0] srNew;
  logic [31:0] busRdata = '0;
  logic busAck = 1'b0, busErr = 1'b0;

  always #4 clk = ~clk;

  exc_entry_seq dut (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excType(excType),
    .excLevel(excLevel), .srIn(srIn), .sspIn(sspIn), .faultPc(faultPc),
    .vbrIn(vbrIn), .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck), .busErr(busErr),
    .busy(busy), .handlerGo(handlerGo), .handlerPc(handlerPc),
    .srNew(srNew), .sspNew(sspNew)
  );

  int total = 0, bad = 0;
  int cycles = 0;

  // bus responder and logs
  logic [7:0]  iackVecCfg = '0;
  logic        iackErrCfg = 1'b0;
  int          ackDelay = 0, waitCnt = 0;
  logic [31:0] firstAddr = '0;
  int          addrMoved = 0, txCnt = 0, wrCnt = 0, iackCnt = 0, goCnt = 0;
  logic [31:0] iackAddr = '0;
  logic [31:0] wrAddr [8];
  logic [31:0] wrData [8];
  logic [31:0] goPc [8];
  logic [15:0] goSr [8];
  logic [31:0] goSsp [8];

  always @(negedge clk) begin
    if (handlerGo && goCnt < 8) begin
      goPc[goCnt] = handlerPc; goSr[goCnt] = srNew; goSsp[goCnt] = sspNew;
      goCnt++;
    end
    if (busAck || busErr) begin
      busAck = 1'b0; busErr = 1'b0;
    end else if (busReq) begin
      if (waitCnt == 0) firstAddr = busAddr;
      if (waitCnt < ackDelay) waitCnt++;
      else begin
        waitCnt = 0;
        if (busAddr !== firstAddr) addrMoved++;
        txCnt++;
        if (busWrite) begin
          if (wrCnt < 8) begin wrAddr[wrCnt] = busAddr; wrData[wrCnt] = busWdata; end
          wrCnt++;
          busAck = 1'b1;
        end else if (busAddr[31:8] == IACK_BASE[31:8]) begin
          iackAddr = busAddr; iackCnt++;
          busRdata = {24'h0, iackVecCfg};
          if (iackErrCfg) busErr = 1'b1; else busAck = 1'b1;
        end else begin
          busRdata = busAddr ^ TBL_XOR;
          busAck = 1'b1;
        end
      end
    end
  end

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
      finishRun();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clearLogs();
    txCnt = 0; wrCnt = 0; iackCnt = 0; goCnt = 0; addrMoved = 0;
  endtask

  task automatic pulseReq(input logic [2:0] t, input logic [2:0] l);
    @(negedge clk); #1;
    excReq = 1'b1; excType = t; excLevel = l;
    @(negedge clk); #1;
    excReq = 1'b0;
  endtask

  task automatic waitGo(input int target, input string req);
    int n = 0;
    while (goCnt < target && n < 400) begin
      @(negedge clk); #1; n++;
    end
    chk(goCnt >= target, req, 32'(goCnt), 32'(target));
  endtask

  function automatic logic [15:0] expSr(input vec_t v);
    logic [15:0] s;
    s = v.sr; s[13] = 1'b1; s[15] = 1'b0;
    if (v.typ == 3'd7) begin s[12] = 1'b0; s[10:8] = v.lvl; end
    return s;
  endfunction

  function automatic logic [7:0] expVec(input vec_t v);
    if (v.typ != 3'd7) return 8'(v.typ) + 8'd2;
    if (v.ackErr) return 8'd24;
    return v.ackVec;
  endfunction

  task automatic runVec(input vec_t v);
    logic [7:0] ev;
    bit irq;
    ev = expVec(v);
    irq = (v.typ == 3'd7);
    clearLogs();
    srIn = v.sr; sspIn = v.ssp; faultPc = v.pc;
    iackVecCfg = v.ackVec; iackErrCfg = v.ackErr;
    pulseReq(v.typ, v.lvl);
    chk(busy == 1'b1, "R9 busy after request", 32'(busy), 32'd1);
    waitGo(1, "R8 handler issued");
    chk(goPc[0] == ((VBR + {22'h0, ev, 2'b00}) ^ TBL_XOR), irq ? (v.ackErr ? "R6 spurious vector" : "R5 ack vector") : "R4 fault vector",
        goPc[0], (VBR + {22'h0, ev, 2'b00}) ^ TBL_XOR);
    chk(goSr[0] == expSr(v), irq ? "R3 irq status" : "R2 fault status", 32'(goSr[0]), 32'(expSr(v)));
    chk(goSsp[0] == v.ssp - 32'd8, "R7 new stack", goSsp[0], v.ssp - 32'd8);
    chk(wrCnt == 2, "R7 write count", 32'(wrCnt), 32'd2);
    chk(wrAddr[0] == v.ssp - 32'd4 && wrData[0] == v.pc, "R7 pc word", wrData[0], v.pc);
    chk(wrAddr[1] == v.ssp - 32'd8 && wrData[1] == {4'h4, 4'h0, ev, v.sr}, "R7 status word",
        wrData[1], {4'h4, 4'h0, ev, v.sr});
    chk(iackCnt == (irq ? 1 : 0), irq ? "R5 one ack cycle" : "R4 no ack cycle", 32'(iackCnt), irq ? 32'd1 : 32'd0);
    if (irq) chk(iackAddr == IACK_BASE + {27'h0, v.lvl, 2'b00}, "R5 ack address", iackAddr, IACK_BASE + {27'h0, v.lvl, 2'b00});
    chk(txCnt == (irq ? 4 : 3) && addrMoved == 0, "R11 accesses", 32'(txCnt), irq ? 32'd4 : 32'd3);
    @(negedge clk); #1;
    chk(busy == 1'b0, "R9 busy drops", 32'(busy), 32'd0);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !busReq && !handlerGo, "R1 in reset", {29'h0, busy, busReq, handlerGo}, 32'd0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !busReq && !handlerGo, "R1 after reset", {29'h0, busy, busReq, handlerGo}, 32'd0);

    for (int i = 0; i < NV; i++) runVec(VECS[i]);

    // R11 slow bus on an interrupt entry
    ackDelay = 3;
    runVec(VECS[3]);
    ackDelay = 0;

    // R10 level 0 interrupt ignored
    clearLogs();
    pulseReq(3'd7, 3'd0);
    for (int k = 0; k < 4; k++) begin
      chk(!busy && !busReq, "R10 level 0 ignored", {30'h0, busy, busReq}, 32'd0);
      @(negedge clk); #1;
    end

    // R9/R10 queued requests: order and level merge
    clearLogs();
    srIn = 16'h0000; sspIn = 32'h0000_7000; faultPc = 32'h5000_0000;
    iackVecCfg = 8'h66; iackErrCfg = 1'b0;
    @(negedge clk); #1;
    excReq = 1'b1; excType = 3'd4; excLevel = 3'd0;
    @(negedge clk); #1;
    excType = 3'd7; excLevel = 3'd2;
    @(negedge clk); #1;
    excType = 3'd1; excLevel = 3'd0;
    @(negedge clk); #1;
    excType = 3'd7; excLevel = 3'd5;
    @(negedge clk); #1;
    excReq = 1'b0;
    waitGo(3, "R9 all queued served");
    chk(goPc[0] == ((VBR + 32'd24) ^ TBL_XOR), "R9 first served type 4", goPc[0], (VBR + 32'd24) ^ TBL_XOR);
    chk(goPc[1] == ((VBR + 32'd12) ^ TBL_XOR), "R9 then type 1", goPc[1], (VBR + 32'd12) ^ TBL_XOR);
    chk(goPc[2] == ((VBR + 32'h198) ^ TBL_XOR), "R9 interrupt last", goPc[2], (VBR + 32'h198) ^ TBL_XOR);
    chk(goSr[2] == 16'h2500, "R10 merged level 5", 32'(goSr[2]), 32'h2500);
    chk(iackCnt == 1 && iackAddr == IACK_BASE + 32'd20, "R10 one ack at level 5", iackAddr, IACK_BASE + 32'd20);
    repeat (3) @(negedge clk);
    #1;
    chk(goCnt == 3 && !busy, "R9 idle after queue", 32'(goCnt), 32'd3);

    finishRun();
  end

endmodule